// File: doc/BRIEF.md
# PCI Slot Hotplug Register Window

This block is a small I/O-decoded register window through which platform firmware inspects the hotplug state of PCI slots and asks for slots to be ejected. It sits on a simple I/O bus with an address, separate read and write strobes, an access size in bytes and 32-bit write data. Three slot vectors come in from the surrounding logic: which slots hold a device, which slots allow hotplug, and which slots have a removal pending.

A read returns data on the clock after the read strobe. The "device check" register is not a latched event register. It is computed on every read as present AND hotplug-enable, so firmware re-checks every populated hotplug slot each time it looks. A write to the eject register produces a single-cycle eject request that carries the written slot mask. The logic that acts on this request lives outside the block.

The window is four 32-bit registers at a base port (default 0xAE00). Their offsets are fixed because firmware decodes them. Data is little-endian, and slot N maps to bit N of each register.

Top module: `hp_win_top`

## Requirements
- R1: A 4-byte read at base+0x0 returns slotPresent AND slotHpEnable on ioRdata, one clock after the read strobe; bit N is slot N.
- R2: A 4-byte read at base+0x4 returns slotDownPending, one clock after the strobe.
- R3: A 4-byte read at base+0x8 returns zero whatever the slot inputs are.
- R4: A 4-byte read at base+0xC returns slotHpEnable, one clock after the strobe.
- R5: A 4-byte write at base+0x8 raises ejectValid for exactly one cycle, on the clock after the write strobe, with ejectMask equal to the written data. ejectMask is zero whenever ejectValid is low.
- R6: A read or write whose ioSize is not 4 is ignored: a read returns zero and a write raises no eject.
- R7: A 4-byte write to base+0x0, 0x4 or 0xC has no effect: no eject pulse, and later reads return the same values as before.
- R8: A read of an address outside base..base+0xF, or one with address bits [1:0] not zero, returns zero. In any cycle without a decoded read, ioRdata is zero.
- R9: While rst_n is low, ioRdata, ejectValid and ejectMask are all zero.
- R10: Eject writes on consecutive cycles produce pulses on consecutive cycles, each carrying its own mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ioAddr | input | 16 | I/O port address |
| ioRd | input | 1 | Read strobe |
| ioWr | input | 1 | Write strobe |
| ioSize | input | 3 | Access size in bytes |
| ioWdata | input | 32 | Write data |
| ioRdata | output | 32 | Read data, valid the cycle after ioRd |
| slotPresent | input | 32 | Slot holds a device, bit N = slot N |
| slotHpEnable | input | 32 | Slot is hotplug capable (removable) |
| slotDownPending | input | 32 | Slot has a removal pending |
| ejectValid | output | 1 | One-cycle eject request |
| ejectMask | output | 32 | Slots to eject, valid with ejectValid |

## Verification
The block holds no state apart from its output registers, so any decode fault shows up one clock after the offending access. It appears either as a wrong ioRdata word or as an eject pulse where none belongs. The bench predicts ejectValid, ejectMask and ioRdata on every cycle, including idle ones. A pulse that is stretched, missing, or carries a stale mask is therefore caught on the cycle it happens. Address aliasing, size filtering and misalignment are each probed with slot inputs set to distinct, non-zero patterns, so a wrong register selection cannot return an expected value by chance.

// File: rtl/hp_win_pkg.sv
package hp_win_pkg;
  localparam int REG_BYTES = 4;
  localparam int REG_W     = 8 * REG_BYTES;

  // Register selector taken from address bits [3:2]
  typedef enum logic [1:0] {
    SEL_UP   = 2'd0,
    SEL_DOWN = 2'd1,
    SEL_EJ   = 2'd2,
    SEL_RMV  = 2'd3
  } hp_sel_e;

  // Strobes from the decoder to the datapath
  typedef struct packed {
    logic rdUp;
    logic rdDown;
    logic rdFeat;
    logic rdRmv;
    logic wrEject;
  } hp_strb_t;
endpackage

// File: rtl/hp_win_ctrl.sv
module hp_win_ctrl
  import hp_win_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE_PORT = 16'hAE00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic              ioRd,
  input  logic              ioWr,
  input  logic [2:0]        ioSize,
  output hp_strb_t          strb
);
  localparam int OFS_BITS = 4;

  logic    inWin;
  logic    aligned;
  logic    sizeOk;
  logic    hit;
  hp_sel_e sel;

  assign inWin   = (ioAddr[ADDR_W-1:OFS_BITS] == BASE_PORT[ADDR_W-1:OFS_BITS]);
  assign aligned = (ioAddr[1:0] == 2'b00);
  assign sizeOk  = (ioSize == 3'(REG_BYTES));
  assign hit     = inWin && aligned && sizeOk;
  assign sel     = hp_sel_e'(ioAddr[3:2]);

  always_comb begin
    strb         = '0;
    strb.rdUp    = hit && ioRd && (sel == SEL_UP);
    strb.rdDown  = hit && ioRd && (sel == SEL_DOWN);
    strb.rdFeat  = hit && ioRd && (sel == SEL_EJ);
    strb.rdRmv   = hit && ioRd && (sel == SEL_RMV);
    strb.wrEject = hit && ioWr && (sel == SEL_EJ);
  end

  // R8
  rd_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strb.rdUp, strb.rdDown, strb.rdFeat, strb.rdRmv}));

  // R6
  bad_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ioSize != 3'd4) |-> (strb == '0));

  // R7
  ej_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.wrEject |-> (ioWr && ioAddr[3:0] == 4'h8));
endmodule

// File: rtl/hp_win_dp.sv
module hp_win_dp
  import hp_win_pkg::*;
#(
  parameter int SLOTS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  hp_strb_t         strb,
  input  logic [REG_W-1:0] ioWdata,
  input  logic [SLOTS-1:0] slotPresent,
  input  logic [SLOTS-1:0] slotHpEnable,
  input  logic [SLOTS-1:0] slotDownPending,
  output logic [REG_W-1:0] ioRdata,
  output logic             ejectValid,
  output logic [SLOTS-1:0] ejectMask
);
  logic [REG_W-1:0] upWord;
  logic [REG_W-1:0] downWord;
  logic [REG_W-1:0] rmvWord;
  logic [REG_W-1:0] rdNext;

  generate
    if (SLOTS == REG_W) begin : g_full
      assign upWord   = slotPresent & slotHpEnable;
      assign downWord = slotDownPending;
      assign rmvWord  = slotHpEnable;
    end else begin : g_pad
      localparam int PAD = REG_W - SLOTS;
      assign upWord   = {{PAD{1'b0}}, slotPresent & slotHpEnable};
      assign downWord = {{PAD{1'b0}}, slotDownPending};
      assign rmvWord  = {{PAD{1'b0}}, slotHpEnable};
    end
  endgenerate

  // Feature register reads as zero, so rdFeat contributes nothing.
  assign rdNext = ({REG_W{strb.rdUp}}   & upWord)
                | ({REG_W{strb.rdDown}} & downWord)
                | ({REG_W{strb.rdRmv}}  & rmvWord);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ioRdata    <= '0;
      ejectValid <= 1'b0;
      ejectMask  <= '0;
    end else begin
      ioRdata    <= rdNext;
      ejectValid <= strb.wrEject;
      ejectMask  <= strb.wrEject ? ioWdata[SLOTS-1:0] : '0;
    end
  end

  // R5
  eject_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ejectValid |-> $past(strb.wrEject));

  // R5
  idle_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ejectValid |-> (ejectMask == '0));

  // R3
  feat_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(strb.rdFeat) |-> (ioRdata == '0));

  // R8
  no_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(strb.rdUp || strb.rdDown || strb.rdRmv) |-> (ioRdata == '0));
endmodule

// File: rtl/hp_win_top.sv
module hp_win_top
  import hp_win_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE_PORT = 16'hAE00,
  parameter int SLOTS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic              ioRd,
  input  logic              ioWr,
  input  logic [2:0]        ioSize,
  input  logic [REG_W-1:0]  ioWdata,
  output logic [REG_W-1:0]  ioRdata,
  input  logic [SLOTS-1:0]  slotPresent,
  input  logic [SLOTS-1:0]  slotHpEnable,
  input  logic [SLOTS-1:0]  slotDownPending,
  output logic              ejectValid,
  output logic [SLOTS-1:0]  ejectMask
);
  hp_strb_t strb;

  hp_win_ctrl #(.ADDR_W(ADDR_W), .BASE_PORT(BASE_PORT)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .ioAddr (ioAddr),
    .ioRd   (ioRd),
    .ioWr   (ioWr),
    .ioSize (ioSize),
    .strb   (strb)
  );

  hp_win_dp #(.SLOTS(SLOTS)) u_dp (
    .clk             (clk),
    .rst_n           (rst_n),
    .strb            (strb),
    .ioWdata         (ioWdata),
    .slotPresent     (slotPresent),
    .slotHpEnable    (slotHpEnable),
    .slotDownPending (slotDownPending),
    .ioRdata         (ioRdata),
    .ejectValid      (ejectValid),
    .ejectMask       (ejectMask)
  );

  // R9
  reset_quiet_chk: assert property (@(posedge clk)
    !$past(rst_n) |-> (!ejectValid && ioRdata == '0));
endmodule

// File: tb/hp_win_top_bench.sv
module hp_win_top_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] ioAddr = '0;
  logic        ioRd = 1'b0;
  logic        ioWr = 1'b0;
  logic [2:0]  ioSize = 3'd4;
  logic [31:0] ioWdata = '0;
  logic [31:0] ioRdata;
  logic [31:0] slotPresent = '0;
  logic [31:0] slotHpEnable = '0;
  logic [31:0] slotDownPending = '0;
  logic        ejectValid;
  logic [31:0] ejectMask;

  int total = 0;
  int bad = 0;
  bit done = 0;

  typedef struct {
    logic [31:0] rd;
    logic        ev;
    logic [31:0] em;
    string       req;
  } exp_t;

  exp_t expQ[$];

  always #4 clk = ~clk;

  hp_win_top u_hp_win_top (
    .clk(clk), .rst_n(rst_n), .ioAddr(ioAddr), .ioRd(ioRd), .ioWr(ioWr),
    .ioSize(ioSize), .ioWdata(ioWdata), .ioRdata(ioRdata),
    .slotPresent(slotPresent), .slotHpEnable(slotHpEnable),
    .slotDownPending(slotDownPending), .ejectValid(ejectValid),
    .ejectMask(ejectMask)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Driver: one bus cycle, plus the outputs expected after the next edge
  task automatic cyc(input logic [15:0] a, input logic rd, input logic wr,
                     input logic [2:0] sz, input logic [31:0] wd,
                     input logic [31:0] eRd, input logic eEv,
                     input logic [31:0] eEm, input string req);
    exp_t e;
    @(negedge clk);
    ioAddr = a; ioRd = rd; ioWr = wr; ioSize = sz; ioWdata = wd;
    e.rd = eRd; e.ev = eEv; e.em = eEm; e.req = req;
    expQ.push_back(e);
  endtask

  task automatic idle(input string req);
    cyc(16'h0000, 1'b0, 1'b0, 3'd4, 32'h0, 32'h0, 1'b0, 32'h0, req);
  endtask

  // Monitor: compares each registered result just after the edge
  always @(posedge clk) begin
    #1;
    if (rst_n && expQ.size() > 0) begin
      exp_t e;
      e = expQ.pop_front();
      check(e.req, ioRdata, e.rd, "ioRdata");
      check(e.req, {31'b0, ejectValid}, {31'b0, e.ev}, "ejectValid");
      check(e.req, ejectMask, e.em, "ejectMask");
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    slotPresent     = 32'h8000_00F5;
    slotHpEnable    = 32'h8000_003C;
    slotDownPending = 32'h0000_0A01;
    // R9: reset state, with a write strobe active during reset
    ioAddr = 16'hAE08; ioWr = 1'b1; ioWdata = 32'hFFFF_FFFF;
    repeat (3) @(posedge clk);
    #1;
    check("R9", ioRdata, 32'h0, "ioRdata");
    check("R9", {31'b0, ejectValid}, 32'h0, "ejectValid");
    check("R9", ejectMask, 32'h0, "ejectMask");
    @(negedge clk);
    ioWr = 1'b0; ioAddr = '0; ioWdata = '0;
    rst_n = 1'b1;

    // R1: up = present & enable
    cyc(16'hAE00, 1, 0, 3'd4, 0, 32'h8000_0034, 0, 0, "R1");
    // R2 down
    cyc(16'hAE04, 1, 0, 3'd4, 0, 32'h0000_0A01, 0, 0, "R2");
    // R3 features always zero
    cyc(16'hAE08, 1, 0, 3'd4, 0, 32'h0, 0, 0, "R3");
    // R4 removable
    cyc(16'hAE0C, 1, 0, 3'd4, 0, 32'h8000_003C, 0, 0, "R4");
    // R8: idle cycle reads zero
    idle("R8");
    // R5 eject pulse, then back to zero
    cyc(16'hAE08, 0, 1, 3'd4, 32'h0000_0024, 0, 1, 32'h0000_0024, "R5");
    idle("R5");
    idle("R5");
    // R10 back-to-back ejects
    cyc(16'hAE08, 0, 1, 3'd4, 32'h0000_0001, 0, 1, 32'h0000_0001, "R10");
    cyc(16'hAE08, 0, 1, 3'd4, 32'h8000_0000, 0, 1, 32'h8000_0000, "R10");
    idle("R10");
    // R6 wrong sizes
    cyc(16'hAE00, 1, 0, 3'd2, 0, 0, 0, 0, "R6");
    cyc(16'hAE0C, 1, 0, 3'd1, 0, 0, 0, 0, "R6");
    cyc(16'hAE08, 0, 1, 3'd2, 32'hFFFF_FFFF, 0, 0, 0, "R6");
    cyc(16'hAE08, 0, 1, 3'd1, 32'hFFFF_FFFF, 0, 0, 0, "R6");
    // R7 writes to other offsets: no eject, values unchanged
    cyc(16'hAE00, 0, 1, 3'd4, 32'hFFFF_FFFF, 0, 0, 0, "R7");
    cyc(16'hAE04, 0, 1, 3'd4, 32'hFFFF_FFFF, 0, 0, 0, "R7");
    cyc(16'hAE0C, 0, 1, 3'd4, 32'hFFFF_FFFF, 0, 0, 0, "R7");
    cyc(16'hAE00, 1, 0, 3'd4, 0, 32'h8000_0034, 0, 0, "R7");
    cyc(16'hAE04, 1, 0, 3'd4, 0, 32'h0000_0A01, 0, 0, "R7");
    cyc(16'hAE0C, 1, 0, 3'd4, 0, 32'h8000_003C, 0, 0, "R7");
    // R8 undecoded and misaligned addresses
    cyc(16'hAE10, 1, 0, 3'd4, 0, 0, 0, 0, "R8");
    cyc(16'hAF00, 1, 0, 3'd4, 0, 0, 0, 0, "R8");
    cyc(16'h2E00, 1, 0, 3'd4, 0, 0, 0, 0, "R8");
    cyc(16'hAE02, 1, 0, 3'd4, 0, 0, 0, 0, "R8");
    cyc(16'hAE0A, 0, 1, 3'd4, 32'hFFFF_FFFF, 0, 0, 0, "R8");
    cyc(16'hAE18, 0, 1, 3'd4, 32'hFFFF_FFFF, 0, 0, 0, "R8");
    // R1 with a second pattern: up tracks live inputs
    @(negedge clk);
    slotPresent = 32'h5555_5555; slotHpEnable = 32'h0F0F_F0F0; slotDownPending = 32'h1234_5678;
    cyc(16'hAE00, 1, 0, 3'd4, 0, 32'h0505_5050, 0, 0, "R1");
    cyc(16'hAE04, 1, 0, 3'd4, 0, 32'h1234_5678, 0, 0, "R2");
    cyc(16'hAE08, 1, 0, 3'd4, 0, 32'h0, 0, 0, "R3");
    cyc(16'hAE0C, 1, 0, 3'd4, 0, 32'h0F0F_F0F0, 0, 0, "R4");
    // read and eject write in the same cycle
    @(negedge clk);
    ioAddr = 16'hAE08; ioRd = 1; ioWr = 1; ioSize = 3'd4; ioWdata = 32'hA5A5_0000;
    begin
      exp_t e;
      e.rd = 32'h0; e.ev = 1'b1; e.em = 32'hA5A5_0000; e.req = "R5";
      expQ.push_back(e);
    end
    idle("R5");
    idle("R8");
    repeat (3) @(negedge clk);
    check("R5", expQ.size(), 0, "queue drained");
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule